// File: doc/BRIEF.md
# Borrow-Free Signed-Digit Subtracter

This block is a purely combinational array of digit positions. It subtracts an unsigned binary operand from a minuend held in radix-2 signed-digit form and returns the difference in the same signed-digit form, so the result can feed the next stage of an iterative multiply or divide cascade directly. Each position holds a sign bit and a magnitude bit. No borrow travels along the array. A position passes one interposition signal to its upper neighbour, and that signal depends only on the position's own two inputs.

Three controls shape the operation. A negate control complements every output sign, which turns the result into −(X−Y). If the caller also complements the minuend signs, the result becomes X+Y. A gate control forces every interposition signal to zero, and the array then acts as a per-position XOR. A split control cuts the link at the midpoint, so each half becomes an independent subtracter with its own negate bit. The top digit of each active segment corrects a spurious overflow by flipping its own output sign. This takes the place of an extra digit position.

Top module: `bfs_subtracter`

## Requirements
- R1: Digit i (weight 2^i, position 0 least significant) is the pair (sign, magnitude) with 00 = +0, 01 = +1, 10 = −0 and 11 = −1. Bit i of the subtrahend has weight 2^i. With gate 1, split 0 and negate 0, the value of the output digits is congruent to X−Y modulo 2^WIDTH.
- R2: With gate 1 and split 0, changing the inputs at position k alters no output digit other than k and k+1.
- R3: With gate 0, every output magnitude equals minuend magnitude XOR subtrahend bit. Every output sign equals the negate bit that applies to its segment, and no correction is made.
- R4: With negate bit 0 set, the output value is congruent to −(X−Y). If the minuend signs are complemented at the input as well, it is congruent to X+Y.
- R5: When X ≡ Y modulo 2^WIDTH, every output magnitude bit is 0, because zero has a single magnitude pattern.
- R6: No borrow enters position 0. Its output magnitude is the minuend magnitude XOR the subtrahend bit, and its sign is negate bit 0.
- R7: With gate 1, a minuend digit of −1 at the top position complemented the top output sign. As a result, when the top subtrahend bit is 0 and X−Y lies strictly between −2^(WIDTH−1) and 2^(WIDTH−1), the output value equals ±(X−Y) exactly.
- R8: With split 1, position WIDTH/2 receives no interposition signal. The lower half (negate bit 0) and the upper half (negate bit 1) each compute their own difference modulo 2^(WIDTH/2). Position WIDTH/2−1 applies the R7 correction for the lower half.
- R9: With split 0, negate bit 1 has no effect, and position WIDTH/2−1 makes no correction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| min_sgn_i | input | WIDTH | Minuend digit signs |
| min_mag_i | input | WIDTH | Minuend digit magnitudes |
| sub_i | input | WIDTH | Subtrahend, unsigned binary |
| gate_i | input | 1 | 1: normal subtraction; 0: all interposition signals forced to zero |
| split_i | input | 1 | 1: array cut into two independent halves |
| neg_i | input | 2 | Bit 0 negates the whole array or the lower half; bit 1 negates the upper half when split |
| dif_sgn_o | output | WIDTH | Difference digit signs |
| dif_mag_o | output | WIDTH | Difference digit magnitudes |

## Verification
The hardest case to reach from the ports is the overflow correction. It is only visible when the result is exact, not merely correct modulo 2^WIDTH. That needs a minuend whose top digit is −1 and whose true difference still fits inside half the range. The stimulus forces the top digit to −1 and the digit just below it to +1, which keeps the lower part positive. It then draws the subtrahend below that lower part, so the exact difference is known and lies inside the range. The same construction is used at the lower half's top digit with split set. Locality is checked by perturbing a single position and comparing every other output digit.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

  typedef struct packed {
    logic sgn;
    logic mag;
  } sdigit_t;

  // Borrow a position hands upward: its local difference is negative.
  function automatic logic borrow_of(input sdigit_t x, input logic y);
    return (x.sgn & x.mag) | (~x.mag & y);
  endfunction

  // Combine the local residue u with the borrow arriving from below.
  function automatic sdigit_t settle(input logic u, input logic c);
    sdigit_t d;
    d.sgn = c;
    d.mag = u ^ c;
    return d;
  endfunction

endpackage

// File: rtl/bfs_cell.sv
module bfs_cell
  import bfs_pkg::*;
(
  input  logic min_sgn_i,
  input  logic min_mag_i,
  input  logic sub_i,
  input  logic gate_i,
  input  logic cin_i,
  output logic bout_o,
  output logic raw_sgn_o,
  output logic mag_o
);

  sdigit_t x_d;
  sdigit_t r_d;
  logic    resid;

  always_comb begin
    x_d.sgn = min_sgn_i;
    x_d.mag = min_mag_i;
    resid   = min_mag_i ^ sub_i;
    r_d     = settle(resid, cin_i);
  end

  assign bout_o    = gate_i & borrow_of(x_d, sub_i);
  assign raw_sgn_o = r_d.sgn;
  assign mag_o     = r_d.mag;

endmodule

// File: rtl/bfs_link.sv
module bfs_link #(
  parameter int unsigned WIDTH = 64
) (
  input  logic [WIDTH-2:0] bout_i,
  input  logic             split_i,
  output logic [WIDTH-1:0] cin_o
);

  localparam int unsigned HALF = WIDTH / 2;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_pos
      if (i == 0) begin : g_lsb
        assign cin_o[i] = 1'b0;
      end else if (i == HALF) begin : g_cut
        assign cin_o[i] = split_i ? 1'b0 : bout_i[i-1];
      end else begin : g_pass
        assign cin_o[i] = bout_i[i-1];
      end
    end
  endgenerate

endmodule

// File: rtl/bfs_sign.sv
module bfs_sign #(
  parameter int unsigned WIDTH = 64
) (
  input  logic [WIDTH-1:0] raw_sgn_i,
  input  logic             top_bout_i,
  input  logic             top_mag_i,
  input  logic             mid_bout_i,
  input  logic             mid_mag_i,
  input  logic             split_i,
  input  logic [1:0]       neg_i,
  output logic [WIDTH-1:0] sgn_o
);

  localparam int unsigned HALF = WIDTH / 2;

  // A dropped borrow caused by a -1 minuend digit is absorbed by a sign flip.
  logic top_flip;
  logic mid_flip;
  logic neg_up;

  assign top_flip = top_bout_i & top_mag_i;
  assign mid_flip = split_i & mid_bout_i & mid_mag_i;
  assign neg_up   = split_i ? neg_i[1] : neg_i[0];

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_pos
      if (i == WIDTH - 1) begin : g_top
        assign sgn_o[i] = raw_sgn_i[i] ^ neg_up ^ top_flip;
      end else if (i == HALF - 1) begin : g_mid
        assign sgn_o[i] = raw_sgn_i[i] ^ neg_i[0] ^ mid_flip;
      end else if (i >= HALF) begin : g_up
        assign sgn_o[i] = raw_sgn_i[i] ^ neg_up;
      end else begin : g_lo
        assign sgn_o[i] = raw_sgn_i[i] ^ neg_i[0];
      end
    end
  endgenerate

endmodule

// File: rtl/bfs_subtracter.sv
module bfs_subtracter #(
  parameter int unsigned WIDTH = 64
) (
  input  logic [WIDTH-1:0] min_sgn_i,
  input  logic [WIDTH-1:0] min_mag_i,
  input  logic [WIDTH-1:0] sub_i,
  input  logic             gate_i,
  input  logic             split_i,
  input  logic [1:0]       neg_i,
  output logic [WIDTH-1:0] dif_sgn_o,
  output logic [WIDTH-1:0] dif_mag_o
);

  localparam int unsigned HALF = WIDTH / 2;

  logic [WIDTH-1:0] bout;
  logic [WIDTH-1:0] cin;
  logic [WIDTH-1:0] raw_sgn;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_cell
      bfs_cell u_cell (
        .min_sgn_i (min_sgn_i[i]),
        .min_mag_i (min_mag_i[i]),
        .sub_i     (sub_i[i]),
        .gate_i    (gate_i),
        .cin_i     (cin[i]),
        .bout_o    (bout[i]),
        .raw_sgn_o (raw_sgn[i]),
        .mag_o     (dif_mag_o[i])
      );
    end
  endgenerate

  bfs_link #(.WIDTH(WIDTH)) u_link (
    .bout_i  (bout[WIDTH-2:0]),
    .split_i (split_i),
    .cin_o   (cin)
  );

  bfs_sign #(.WIDTH(WIDTH)) u_sign (
    .raw_sgn_i  (raw_sgn),
    .top_bout_i (bout[WIDTH-1]),
    .top_mag_i  (min_mag_i[WIDTH-1]),
    .mid_bout_i (bout[HALF-1]),
    .mid_mag_i  (min_mag_i[HALF-1]),
    .split_i    (split_i),
    .neg_i      (neg_i),
    .sgn_o      (dif_sgn_o)
  );

endmodule

// File: rtl/bfs_subtracter_chk.sv
module bfs_subtracter_chk #(
  parameter int unsigned WIDTH = 64
) (
  input logic [WIDTH-1:0] min_sgn_i,
  input logic [WIDTH-1:0] min_mag_i,
  input logic [WIDTH-1:0] sub_i,
  input logic             gate_i,
  input logic             split_i,
  input logic [1:0]       neg_i,
  input logic [WIDTH-1:0] dif_sgn_o,
  input logic [WIDTH-1:0] dif_mag_o
);

  localparam int unsigned HALF = WIDTH / 2;

  logic [WIDTH-1:0] neg_map;
  logic             unused_sgn;

  assign neg_map    = {{HALF{split_i ? neg_i[1] : neg_i[0]}}, {HALF{neg_i[0]}}};
  assign unused_sgn = ^min_sgn_i;

  always_comb begin
    if (!gate_i) begin
      AST_GATE_MAG: assert (dif_mag_o == (min_mag_i ^ sub_i)); // R3
      AST_GATE_SGN: assert (dif_sgn_o == neg_map);             // R3
    end
    AST_LSB_MAG: assert (dif_mag_o[0] == (min_mag_i[0] ^ sub_i[0])); // R6
    AST_LSB_SGN: assert (dif_sgn_o[0] == neg_i[0]);                  // R6
    if (split_i) begin
      AST_CUT_MAG: assert (dif_mag_o[HALF] == (min_mag_i[HALF] ^ sub_i[HALF])); // R8
      AST_CUT_SGN: assert (dif_sgn_o[HALF] == neg_i[1]);                        // R8
    end
  end

endmodule

bind bfs_subtracter bfs_subtracter_chk #(.WIDTH(WIDTH)) chk_i (
  .min_sgn_i (min_sgn_i),
  .min_mag_i (min_mag_i),
  .sub_i     (sub_i),
  .gate_i    (gate_i),
  .split_i   (split_i),
  .neg_i     (neg_i),
  .dif_sgn_o (dif_sgn_o),
  .dif_mag_o (dif_mag_o)
);

// File: tb/bfs_subtracter_tb_top.sv
module bfs_subtracter_tb_top;

  localparam int W          = 64;
  localparam int HALF       = W / 2;
  localparam int CLK_PERIOD = 10;

  typedef logic signed [71:0] val_t;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] min_sgn, min_mag, sub;
  logic         gate, split;
  logic [1:0]   neg;
  logic [W-1:0] dif_sgn, dif_mag;

  int checks = 0;
  int errors = 0;

  bfs_subtracter #(.WIDTH(W)) dut_i (
    .min_sgn_i (min_sgn),
    .min_mag_i (min_mag),
    .sub_i     (sub),
    .gate_i    (gate),
    .split_i   (split),
    .neg_i     (neg),
    .dif_sgn_o (dif_sgn),
    .dif_mag_o (dif_mag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic val_t sd_val(input logic [W-1:0] s, input logic [W-1:0] m,
                                  input int lo, input int hi);
    val_t v = '0;
    for (int i = lo; i <= hi; i++) begin
      if (m[i]) v = s[i] ? v - (val_t'(1) <<< (i - lo)) : v + (val_t'(1) <<< (i - lo));
    end
    return v;
  endfunction

  function automatic val_t u_val(input logic [W-1:0] y, input int lo, input int hi);
    val_t v = '0;
    for (int i = lo; i <= hi; i++) begin
      if (y[i]) v = v + (val_t'(1) <<< (i - lo));
    end
    return v;
  endfunction

  function automatic bit eq_mod(input val_t a, input val_t b, input int bits);
    val_t d;
    val_t mask;
    d    = a - b;
    mask = (val_t'(1) <<< bits) - val_t'(1);
    return (d & mask) == '0;
  endfunction

  function automatic logic [W-1:0] rnd();
    return {$urandom(), $urandom()};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input val_t act, input val_t exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] s, input logic [W-1:0] m, input logic [W-1:0] y,
                       input logic g, input logic sp, input logic [1:0] n);
    @(negedge clk);
    min_sgn = s; min_mag = m; sub = y; gate = g; split = sp; neg = n;
    #1;
  endtask

  task automatic t_reset_zero();
    val_t a;
    a = sd_val(dif_sgn, dif_mag, 0, W-1);
    check(dif_mag == '0 && dif_sgn == '0, "R5", "idle outputs", a, 0);
  endtask

  task automatic t_random_sub(input int n);
    for (int k = 0; k < n; k++) begin
      logic [W-1:0] s, m, y;
      val_t e, a;
      s = rnd(); m = rnd(); y = rnd();
      apply(s, m, y, 1'b1, 1'b0, 2'b00);
      e = sd_val(s, m, 0, W-1) - u_val(y, 0, W-1);
      a = sd_val(dif_sgn, dif_mag, 0, W-1);
      check(eq_mod(a, e, W), "R1", "X-Y mod 2^W", a, e);
    end
  endtask

  task automatic t_negate(input int n);
    for (int k = 0; k < n; k++) begin
      logic [W-1:0] s, m, y;
      val_t e, a;
      s = rnd(); m = rnd(); y = rnd();
      apply(s, m, y, 1'b1, 1'b0, 2'b01);
      e = u_val(y, 0, W-1) - sd_val(s, m, 0, W-1);
      a = sd_val(dif_sgn, dif_mag, 0, W-1);
      check(eq_mod(a, e, W), "R4", "-(X-Y)", a, e);
    end
  endtask

  task automatic t_add(input int n);
    for (int k = 0; k < n; k++) begin
      logic [W-1:0] s, m, y;
      val_t e, a;
      s = rnd(); m = rnd(); y = rnd();
      apply(~s, m, y, 1'b1, 1'b0, 2'b01);
      e = sd_val(s, m, 0, W-1) + u_val(y, 0, W-1);
      a = sd_val(dif_sgn, dif_mag, 0, W-1);
      check(eq_mod(a, e, W), "R4", "X+Y", a, e);
    end
  endtask

  task automatic t_zero(input int n);
    for (int k = 0; k < n; k++) begin
      logic [W-1:0] s, m, y;
      val_t vx;
      s = rnd(); m = rnd();
      vx = sd_val(s, m, 0, W-1);
      y = vx[W-1:0];
      apply(s, m, y, 1'b1, 1'b0, {1'b0, k[0]});
      check(dif_mag == '0, "R5", "zero magnitudes", val_t'(dif_mag), 0);
    end
  endtask

  task automatic t_gate(input int n);
    for (int k = 0; k < n; k++) begin
      logic [W-1:0] s, m, y, es;
      logic [1:0] ng;
      logic sp;
      s = rnd(); m = rnd(); y = rnd(); ng = k[1:0]; sp = k[2];
      s[W-1] = 1'b1; m[W-1] = 1'b1;
      apply(s, m, y, 1'b0, sp, ng);
      es = {{HALF{sp ? ng[1] : ng[0]}}, {HALF{ng[0]}}};
      check(dif_mag == (m ^ y), "R3", "gate-off magnitude",
            val_t'({8'd0, dif_mag}), val_t'({8'd0, m ^ y}));
      check(dif_sgn == es, "R3", "gate-off sign",
            val_t'({8'd0, dif_sgn}), val_t'({8'd0, es}));
    end
  endtask

  task automatic t_lsb(input int n);
    for (int k = 0; k < n; k++) begin
      logic [W-1:0] s, m, y;
      s = rnd(); m = rnd(); y = rnd();
      apply(s, m, y, 1'b1, 1'b0, {1'b0, k[0]});
      check(dif_mag[0] == (m[0] ^ y[0]) && dif_sgn[0] == k[0], "R6", "position 0 digit",
            val_t'({dif_sgn[0], dif_mag[0]}), val_t'({k[0], m[0] ^ y[0]}));
    end
  endtask

  task automatic t_locality(input int n);
    for (int k = 0; k < n; k++) begin
      logic [W-1:0] s, m, y, s1, m1, mask;
      int p;
      s = rnd(); m = rnd(); y = rnd();
      p = 1 + int'($urandom_range(W - 3));
      apply(s, m, y, 1'b1, 1'b0, 2'b00);
      s1 = dif_sgn; m1 = dif_mag;
      s[p] = ~s[p]; m[p] = ~m[p]; y[p] = ~y[p];
      apply(s, m, y, 1'b1, 1'b0, 2'b00);
      mask = ~((W'(3)) << p);
      check((((s1 ^ dif_sgn) | (m1 ^ dif_mag)) & mask) == '0, "R2", "digits outside k,k+1",
            val_t'({8'd0, ((s1 ^ dif_sgn) | (m1 ^ dif_mag)) & mask}), 0);
    end
  endtask

  task automatic t_correction(input int n);
    for (int k = 0; k < n; k++) begin
      logic [W-1:0] s, m, y;
      val_t rest, yv, e, a;
      s = rnd(); m = rnd();
      s[W-1] = 1'b1; m[W-1] = 1'b1; s[W-2] = 1'b0; m[W-2] = 1'b1;
      rest = sd_val(s, m, 0, W-2);
      yv = val_t'({8'd0, rnd()}) % rest;
      y = yv[W-1:0];
      apply(s, m, y, 1'b1, 1'b0, {1'b0, k[0]});
      e = sd_val(s, m, 0, W-1) - yv;
      if (k[0]) e = -e;
      a = sd_val(dif_sgn, dif_mag, 0, W-1);
      check(a == e, "R7", "exact result with top digit -1", a, e);
    end
  endtask

  task automatic t_split(input int n);
    for (int k = 0; k < n; k++) begin
      logic [W-1:0] s, m, y;
      logic [1:0] ng;
      val_t el, eh, al, ah;
      s = rnd(); m = rnd(); y = rnd(); ng = k[1:0];
      apply(s, m, y, 1'b1, 1'b1, ng);
      el = sd_val(s, m, 0, HALF-1) - u_val(y, 0, HALF-1);
      eh = sd_val(s, m, HALF, W-1) - u_val(y, HALF, W-1);
      if (ng[0]) el = -el;
      if (ng[1]) eh = -eh;
      al = sd_val(dif_sgn, dif_mag, 0, HALF-1);
      ah = sd_val(dif_sgn, dif_mag, HALF, W-1);
      check(eq_mod(al, el, HALF), "R8", "lower segment", al, el);
      check(eq_mod(ah, eh, HALF), "R8", "upper segment", ah, eh);
    end
  endtask

  task automatic t_split_correction(input int n);
    for (int k = 0; k < n; k++) begin
      logic [W-1:0] s, m, y;
      val_t rest, yl, e, a;
      s = rnd(); m = rnd(); y = rnd();
      s[HALF-1] = 1'b1; m[HALF-1] = 1'b1; s[HALF-2] = 1'b0; m[HALF-2] = 1'b1;
      rest = sd_val(s, m, 0, HALF-2);
      yl = val_t'({40'd0, $urandom()}) % rest;
      y[HALF-1:0] = yl[HALF-1:0];
      apply(s, m, y, 1'b1, 1'b1, {k[1], k[0]});
      e = sd_val(s, m, 0, HALF-1) - yl;
      if (k[0]) e = -e;
      a = sd_val(dif_sgn, dif_mag, 0, HALF-1);
      check(a == e, "R8", "exact lower segment with its top digit -1", a, e);
    end
  endtask

  task automatic t_neg_hi_ignored(input int n);
    for (int k = 0; k < n; k++) begin
      logic [W-1:0] s, m, y, s1, m1;
      s = rnd(); m = rnd(); y = rnd();
      s[HALF-1] = 1'b1; m[HALF-1] = 1'b1;
      apply(s, m, y, 1'b1, 1'b0, {1'b0, k[0]});
      s1 = dif_sgn; m1 = dif_mag;
      apply(s, m, y, 1'b1, 1'b0, {1'b1, k[0]});
      check(s1 == dif_sgn && m1 == dif_mag, "R9", "negate bit 1 while unsplit",
            val_t'({8'd0, dif_sgn}), val_t'({8'd0, s1}));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    min_sgn = '0; min_mag = '0; sub = '0; gate = 1'b1; split = 1'b0; neg = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset_zero();
    t_random_sub(200);
    t_negate(200);
    t_add(200);
    t_zero(50);
    t_gate(40);
    t_lsb(20);
    t_locality(100);
    t_correction(200);
    t_split(100);
    t_split_correction(100);
    t_neg_hi_ignored(40);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule